// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block lets a clocked host read and write an external asynchronous static RAM of 512K bytes. The host presents a request with an address, a read/write flag and write data, and holds it until the controller pulses ready. For a read, the byte fetched from the memory appears on the read-data output in that same ready cycle. On the memory side the controller drives two chip enables of opposite polarity, an active-low write enable, an active-low output enable, the address, and a data bus split into an output value, an output-enable and an input value.

Every access is timed by counting clock cycles. The number of cycles for read access, for the write pulse and for bus turnaround are parameters. Writes end when write enable rises while the enables are still active. The address and the write data stay unchanged for one more cycle after that edge. If the access before a write was a read, write enable falls first and the data bus is driven only after a turnaround interval. Between accesses the memory is deselected, which puts it in its low-power standby state.

Top module: `sram_ctrl`

## Requirements
- R1: After reset and whenever no access is in progress, the memory is deselected (enable-1 high, enable-2 low), write enable and output enable are high, the data bus is not driven and ready is low.
- R2: A read holds both enables active, write enable high and output enable low for exactly RD_WAIT_CYC cycles, never drives the data bus, and returns the byte at the requested address on rdata_o when ready pulses.
- R3: A write drives the data bus with write enable low for exactly WR_PULSE_CYC cycles. Then comes one cycle with write enable high, enables still active, and the same data and address still driven. Ready follows in the next cycle.
- R4: A write whose preceding access was a read first spends TURN_CYC cycles with write enable low and the data bus not driven. A write after a write, or the first access after reset, has no such interval.
- R5: Output enable stays high for the whole of a write.
- R6: Ready is high for exactly one cycle per access. A request still held high during that cycle does not start a new access.
- R7: The address on the memory pins equals the requested address and does not change for as long as the enables are active.
- R8: The controller never drives the data bus while output enable is low.
- R9: In the cycle in which ready is high, the memory is deselected.
- R10: rdata_o keeps the last value read until the next read completes; writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until ready_o |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW (19) | Byte address |
| wdata_i | input | DW (8) | Write data |
| ready_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DW (8) | Last byte read |
| sram_addr_o | output | AW (19) | Memory address pins |
| sram_ce1_n_o | output | 1 | Chip enable 1, active low |
| sram_ce2_o | output | 1 | Chip enable 2, active high |
| sram_we_n_o | output | 1 | Write enable, active low |
| sram_oe_n_o | output | 1 | Output enable, active low |
| sram_dq_o | output | DW (8) | Data bus value to drive |
| sram_dq_oe_o | output | 1 | Data bus driver enable |
| sram_dq_i | input | DW (8) | Data bus value received |

## Verification
The request is applied before clock edge 0, and the access starts at that edge. Ready is then due at the falling edge RD_WAIT_CYC+1 for a read, and at WR_PULSE_CYC+2 for a write, plus TURN_CYC when the write follows a read. The bench drives stimulus and samples only on falling edges. At each falling edge it counts how many cycles fall in each phase (turnaround, pulse, hold, output enabled) and compares both the counts and the total latency with these figures. The memory model drives valid data only from cycle RD_WAIT_CYC of an enabled read and garbage before that, so capturing a cycle early shows up as a wrong byte. One extra falling edge after ready confirms that the pulse has ended and that no new access has started.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_WAIT,
    ST_WR_TURN,
    ST_WR_PULSE,
    ST_WR_HOLD
  } seq_state_e;
endpackage

// File: rtl/sram_wait_cnt.sv
module sram_wait_cnt #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= load_val_i;
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sram_dq_path.sv
module sram_dq_path #(
  parameter int AW = 19,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          latch_i,
  input  logic          capture_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] dq_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rdata_o
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (latch_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  // sampled on the last wait cycle, while output enable is still low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_q <= '0;
    else if (capture_i) rdata_q <= dq_i;
  end

  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_WAIT_CYC  = 2,
  parameter int WR_PULSE_CYC = 2,
  parameter int TURN_CYC     = 1,
  parameter int CNT_W        = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             cnt_done_i,
  output logic             cnt_load_o,
  output logic [CNT_W-1:0] cnt_val_o,
  output logic             latch_o,
  output logic             capture_o,
  output logic             ready_o,
  output logic             sel_o,
  output logic             we_n_o,
  output logic             oe_n_o,
  output logic             dq_oe_o
);
  localparam logic [CNT_W-1:0] RdLd   = CNT_W'(RD_WAIT_CYC - 1);
  localparam logic [CNT_W-1:0] WrLd   = CNT_W'(WR_PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] TurnLd = CNT_W'((TURN_CYC > 0) ? TURN_CYC - 1 : 0);

  seq_state_e state_q, state_d;
  logic       ready_q, ready_d;
  logic       after_rd;

  always_comb begin
    state_d    = state_q;
    cnt_load_o = 1'b0;
    cnt_val_o  = '0;
    latch_o    = 1'b0;
    capture_o  = 1'b0;
    ready_d    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i && !ready_q) begin
          latch_o    = 1'b1;
          cnt_load_o = 1'b1;
          if (!we_i) begin
            state_d   = ST_RD_WAIT;
            cnt_val_o = RdLd;
          end else if (after_rd) begin
            state_d   = ST_WR_TURN;
            cnt_val_o = TurnLd;
          end else begin
            state_d   = ST_WR_PULSE;
            cnt_val_o = WrLd;
          end
        end
      end
      ST_RD_WAIT: begin
        if (cnt_done_i) begin
          capture_o = 1'b1;
          ready_d   = 1'b1;
          state_d   = ST_IDLE;
        end
      end
      ST_WR_TURN: begin
        if (cnt_done_i) begin
          state_d    = ST_WR_PULSE;
          cnt_load_o = 1'b1;
          cnt_val_o  = WrLd;
        end
      end
      ST_WR_PULSE: begin
        if (cnt_done_i) state_d = ST_WR_HOLD;
      end
      ST_WR_HOLD: begin
        ready_d = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ready_q <= ready_d;
    end
  end

  generate
    if (TURN_CYC > 0) begin : g_turn
      logic after_rd_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                   after_rd_q <= 1'b0;
        else if (capture_o)            after_rd_q <= 1'b1;
        else if (state_q == ST_WR_HOLD) after_rd_q <= 1'b0;
      end
      assign after_rd = after_rd_q;
    end else begin : g_no_turn
      assign after_rd = 1'b0;
    end
  endgenerate

  assign ready_o = ready_q;
  assign sel_o   = (state_q != ST_IDLE);
  assign we_n_o  = !((state_q == ST_WR_TURN) || (state_q == ST_WR_PULSE));
  assign oe_n_o  = (state_q != ST_RD_WAIT);
  assign dq_oe_o = (state_q == ST_WR_PULSE) || (state_q == ST_WR_HOLD);
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
  parameter int AW           = 19,
  parameter int DW           = 8,
  parameter int RD_WAIT_CYC  = 2,
  parameter int WR_PULSE_CYC = 2,
  parameter int TURN_CYC     = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ready_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] sram_addr_o,
  output logic          sram_ce1_n_o,
  output logic          sram_ce2_o,
  output logic          sram_we_n_o,
  output logic          sram_oe_n_o,
  output logic [DW-1:0] sram_dq_o,
  output logic          sram_dq_oe_o,
  input  logic [DW-1:0] sram_dq_i
);
  localparam int MaxCyc = (RD_WAIT_CYC > WR_PULSE_CYC)
                        ? ((RD_WAIT_CYC > TURN_CYC) ? RD_WAIT_CYC : TURN_CYC)
                        : ((WR_PULSE_CYC > TURN_CYC) ? WR_PULSE_CYC : TURN_CYC);
  localparam int CntW = (MaxCyc < 2) ? 1 : $clog2(MaxCyc);

  logic            cnt_load, cnt_done, latch, capture, sel;
  logic [CntW-1:0] cnt_val;

  sram_wait_cnt #(.W(CntW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .done_o     (cnt_done)
  );

  sram_seq_fsm #(
    .RD_WAIT_CYC  (RD_WAIT_CYC),
    .WR_PULSE_CYC (WR_PULSE_CYC),
    .TURN_CYC     (TURN_CYC),
    .CNT_W        (CntW)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .cnt_done_i (cnt_done),
    .cnt_load_o (cnt_load),
    .cnt_val_o  (cnt_val),
    .latch_o    (latch),
    .capture_o  (capture),
    .ready_o    (ready_o),
    .sel_o      (sel),
    .we_n_o     (sram_we_n_o),
    .oe_n_o     (sram_oe_n_o),
    .dq_oe_o    (sram_dq_oe_o)
  );

  sram_dq_path #(.AW(AW), .DW(DW)) u_dq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .latch_i   (latch),
    .capture_i (capture),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .dq_i      (sram_dq_i),
    .addr_o    (sram_addr_o),
    .wdata_o   (sram_dq_o),
    .rdata_o   (rdata_o)
  );

  assign sram_ce1_n_o = !sel;
  assign sram_ce2_o   = sel;
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int AW = 19,
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ready_o,
  input logic [AW-1:0] sram_addr_o,
  input logic          sram_ce1_n_o,
  input logic          sram_ce2_o,
  input logic          sram_we_n_o,
  input logic          sram_oe_n_o,
  input logic [DW-1:0] sram_dq_o,
  input logic          sram_dq_oe_o
);
  AST_STANDBY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_ce1_n_o |-> (sram_we_n_o && sram_oe_n_o && !sram_dq_oe_o)); // R1

  AST_READ_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_oe_n_o |-> (sram_we_n_o && !sram_ce1_n_o && sram_ce2_o)); // R2

  AST_WRITE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_n_o) |-> (sram_dq_oe_o && $stable(sram_dq_o) && !sram_ce1_n_o)); // R3

  AST_WRITE_OE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_n_o |-> sram_oe_n_o); // R5

  AST_READY_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o); // R6

  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_ce1_n_o && $past(!sram_ce1_n_o)) |-> $stable(sram_addr_o)); // R7

  AST_NO_CONTENTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sram_dq_oe_o && !sram_oe_n_o)); // R8

  AST_READY_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (sram_ce1_n_o && !sram_ce2_o)); // R9
endmodule

bind sram_ctrl sram_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sram_ctrl_test.sv
module sram_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 19;
  localparam int DW = 8;
  localparam int RD_WAIT_CYC  = 2;
  localparam int WR_PULSE_CYC = 2;
  localparam int TURN_CYC     = 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          ready;
  logic [DW-1:0] rdata;
  logic [AW-1:0] s_addr;
  logic          ce1_n, ce2, we_n, oe_n, dq_oe;
  logic [DW-1:0] dq_o, dq_i;

  int  n_chk = 0, n_bad = 0;
  bit  done = 0;
  logic [DW-1:0] last_rd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_ctrl #(.AW(AW), .DW(DW), .RD_WAIT_CYC(RD_WAIT_CYC),
              .WR_PULSE_CYC(WR_PULSE_CYC), .TURN_CYC(TURN_CYC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ready_o(ready), .rdata_o(rdata), .sram_addr_o(s_addr),
    .sram_ce1_n_o(ce1_n), .sram_ce2_o(ce2), .sram_we_n_o(we_n),
    .sram_oe_n_o(oe_n), .sram_dq_o(dq_o), .sram_dq_oe_o(dq_oe),
    .sram_dq_i(dq_i)
  );

  // memory model, 256 bytes decoded from the low address bits
  logic [7:0] mem [0:255];
  logic [3:0] rd_age;
  wire m_sel = !ce1_n && ce2;
  wire m_rd  = m_sel && we_n && !oe_n;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) rd_age <= '0;
    else        rd_age <= m_rd ? ((rd_age == 4'hF) ? rd_age : rd_age + 4'd1) : 4'd0;

  assign dq_i = (m_rd && (int'(rd_age) >= RD_WAIT_CYC - 1)) ? mem[s_addr[7:0]] : 8'hEE;

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  always @(posedge we_n) begin
    if (m_sel) begin
      check(dq_oe == 1'b1, "R3 data driven at write end", int'(dq_oe), 1);
      mem[s_addr[7:0]] = dq_o;
    end
  end

  always @(negedge clk)
    if (rst_n && dq_oe && m_rd) check(1'b0, "R8 bus contention", 1, 0);

  task automatic run_req(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         output int lat, output int n_turn, output int n_pulse,
                         output int n_hold, output int n_oe);
    bit addr_ok = 1;
    @(negedge clk);
    req = 1'b1; we = wr; addr = a; wdata = d;
    lat = 0; n_turn = 0; n_pulse = 0; n_hold = 0; n_oe = 0;
    do begin
      @(negedge clk);
      lat++;
      if (m_sel) begin
        if (!we_n && !dq_oe) n_turn++;
        if (!we_n && dq_oe)  n_pulse++;
        if (we_n && dq_oe)   n_hold++;
        if (!oe_n)           n_oe++;
        if (s_addr !== a)    addr_ok = 0;
      end
    end while (!ready && lat < 40);
    check(addr_ok, "R7 address on pins", int'(s_addr), int'(a));
    check(!m_sel, "R9 deselected with ready", int'(m_sel), 0);
    // request still held through the ready cycle
    @(negedge clk);
    check(!ready, "R6 ready single cycle", int'(ready), 0);
    check(!m_sel, "R6 held request not restarted", int'(m_sel), 0);
    check(ce1_n && !ce2 && we_n && oe_n && !dq_oe, "R1 standby between accesses",
          int'({ce1_n, ce2, we_n, oe_n, dq_oe}), 'b10110);
    req = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(ce1_n && !ce2 && we_n && oe_n && !dq_oe && !ready, "R1 reset state",
          int'({ce1_n, ce2, we_n, oe_n, dq_oe, ready}), 'b101100);
    rst_n = 1'b1;
    @(negedge clk);
    check(ce1_n && !ce2 && !ready, "R1 idle after reset", int'({ce1_n, ce2, ready}), 'b100);
  endtask

  task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input int exp_turn);
    int lat, nt, np, nh, no;
    run_req(1'b1, a, d, lat, nt, np, nh, no);
    check(lat == exp_turn + WR_PULSE_CYC + 2, "R3 write latency", lat, exp_turn + WR_PULSE_CYC + 2);
    check(nt == exp_turn, "R4 turnaround cycles", nt, exp_turn);
    check(np == WR_PULSE_CYC, "R3 pulse cycles", np, WR_PULSE_CYC);
    check(nh == 1, "R3 hold cycle", nh, 1);
    check(no == 0, "R5 output enable during write", no, 0);
    check(mem[a[7:0]] == d, "R3 byte stored", int'(mem[a[7:0]]), int'(d));
    check(rdata == last_rd, "R10 rdata kept over write", int'(rdata), int'(last_rd));
  endtask

  task automatic t_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
    int lat, nt, np, nh, no;
    logic [DW-1:0] got;
    run_req(1'b0, a, 8'h00, lat, nt, np, nh, no);
    got = rdata;
    check(lat == RD_WAIT_CYC + 1, "R2 read latency", lat, RD_WAIT_CYC + 1);
    check(no == RD_WAIT_CYC, "R2 output enable cycles", no, RD_WAIT_CYC);
    check(np + nh + nt == 0, "R2 no drive in read", np + nh + nt, 0);
    check(got == exp, "R2 read data", int'(got), int'(exp));
    last_rd = exp;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    t_reset();
    t_write(19'h00000, 8'h5A, 0);          // first access: no turnaround
    t_write(19'h7FFFF, 8'hA5, 0);          // top address
    t_read (19'h00000, 8'h5A);
    t_write(19'h12345, 8'h3C, TURN_CYC);   // R4 write after read
    t_read (19'h7FFFF, 8'hA5);
    t_read (19'h12345, 8'h3C);             // read after read
    t_write(19'h40001, 8'hC3, TURN_CYC);
    t_write(19'h40002, 8'h0F, 0);          // R4 write after write
    t_read (19'h40001, 8'hC3);
    t_read (19'h40002, 8'h0F);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule